// File: doc/BRIEF.md
# Companion-Chip System Control Register Window

This block is the system-control register window of a multifunction I/O companion chip. The host reaches it with single-byte accesses, and an access selects the window only when every address bit above bit 7 is zero. Inside the window the block does three jobs. It collects eight sub-device interrupt lines into a status byte and masks that byte to drive one host interrupt. It holds a 24-bit general-purpose output level and a 24-bit output enable, and drives sixteen pins with their gated value. It also keeps a set of clock, PLL, mode and miscellaneous configuration bytes as plain storage.

Reads are combinational. `acc_rdata` is valid in the cycle in which `acc_en` is high. Writes take effect at the clock edge that ends the access. The pin bus is registered, so it follows a write that changes it one clock later.

Top module: `sysctl_regs`

## Requirements
- R1: An access hits the window only when `acc_en` is high and `acc_addr[15:8]` is zero. A write outside the window changes no register. A read outside the window, or with `acc_en` low, returns 0x00.
- R2: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to either offset have no effect.
- R3: Interrupt status (0x50), interrupt mask (0x52) and interrupt routing (0x54) are byte registers. The host can write each one and read it back. A host write to status stores the written byte in every bit whose input line did not change in that cycle.
- R4: Sub-device line k (0 NAND, 1 MMC, 2 USB host, 3 serial, 4 framebuffer, 5–7 spare) drives status bit k. In every cycle in which the line differs from its previous sampled level, the bit takes the new level. A steady line leaves the bit alone, so a host clear stays in place until the line toggles again.
- R5: `host_irq` is high exactly when (status AND mask) is nonzero.
- R6: The output level is three bytes at 0x78, 0x79 and 0x7A. The output enable is three bytes at 0x7C, 0x7D and 0x7E. Byte n holds pins 8n to 8n+7, with bit 0 of the byte as the lowest pin. All six bytes read back as written.
- R7: `pin_out[i]` equals level[i] AND enable[i] for i = 0..15. The output changes one clock after the write that changes the gated value, and it holds while that value is unchanged. Level and enable bits 16–23 never reach a pin.
- R8: The 16-bit registers at 0x60, 0x98, 0x9A and 0xE4 (low byte first) and the 32-bit register at 0x9C (bytes 0x9C–0x9F) are written one byte lane at a time. A write to one lane leaves every other lane unchanged.
- R9: The byte registers at 0xA0, 0xA1, 0xE0, 0xFC and 0xFF, and the three-byte arrays starting at 0x64, 0x68, 0x6C, 0x70, 0x80, 0x84 and 0x88, store and return what is written.
- R10: Every offset in the window not named in R2–R9 reads 0x00 and ignores writes. After reset every register is 0x00, `host_irq` is low and `pin_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Byte access valid this cycle |
| acc_we | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 16 | Host byte address |
| acc_wdata | input | 8 | Write byte |
| acc_rdata | output | 8 | Read byte, combinational |
| sub_irq | input | 8 | Sub-device interrupt lines |
| host_irq | output | 1 | Masked interrupt to the host |
| pin_out | output | 16 | Gated general-purpose output pins |

## Verification
The bench first writes a distinct byte to every one of the 256 offsets, then reads every offset back. This separates stored offsets from unmapped ones and from the read-only revision pair in a single pass, and it exposes any address decode that aliases two registers. The mask is then swept over all 256 values under five line patterns: single low, middle and top bits, a checkerboard, and none. This tells a correct AND-reduce apart from a wrong bit order or an OR of the two registers. A walking one across all 24 output bits shows both the byte-to-pin mapping and the one-clock lag, and the upper byte is shown to stay off the pins. Lane rewrites, a host clear against a steady line, and writes above the window cover the storage-preservation and ignore cases.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned CFG_SLOTS = 38;
  localparam int unsigned SLOT_W    = $clog2(CFG_SLOTS);

  localparam logic [7:0] OFF_REV_LO = 8'h08;
  localparam logic [7:0] OFF_REV_HI = 8'h09;
  localparam logic [7:0] OFF_STAT   = 8'h50;
  localparam logic [7:0] OFF_MASK   = 8'h52;
  localparam logic [7:0] OFF_ROUTE  = 8'h54;
  localparam logic [7:0] OFF_LVL    = 8'h78;
  localparam logic [7:0] OFF_OE     = 8'h7C;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] idx;
  } slot_t;

  function automatic logic [7:0] array_base(input int unsigned k);
    case (k)
      0: array_base = 8'h64;
      1: array_base = 8'h68;
      2: array_base = 8'h6C;
      3: array_base = 8'h70;
      4: array_base = 8'h80;
      5: array_base = 8'h84;
      default: array_base = 8'h88;
    endcase
  endfunction

  // Map a window offset onto a storage slot of the configuration bank.
  function automatic slot_t cfg_lookup(input logic [7:0] off);
    slot_t s;
    s.hit = 1'b1;
    s.idx = '0;
    case (off)
      8'h60: s.idx = SLOT_W'(0);
      8'h61: s.idx = SLOT_W'(1);
      8'h98: s.idx = SLOT_W'(23);
      8'h99: s.idx = SLOT_W'(24);
      8'h9A: s.idx = SLOT_W'(25);
      8'h9B: s.idx = SLOT_W'(26);
      8'h9C: s.idx = SLOT_W'(27);
      8'h9D: s.idx = SLOT_W'(28);
      8'h9E: s.idx = SLOT_W'(29);
      8'h9F: s.idx = SLOT_W'(30);
      8'hA0: s.idx = SLOT_W'(31);
      8'hA1: s.idx = SLOT_W'(32);
      8'hE0: s.idx = SLOT_W'(33);
      8'hE4: s.idx = SLOT_W'(34);
      8'hE5: s.idx = SLOT_W'(35);
      8'hFC: s.idx = SLOT_W'(36);
      8'hFF: s.idx = SLOT_W'(37);
      default: begin
        s.hit = 1'b0;
        for (int unsigned k = 0; k < 7; k++) begin
          if (off >= array_base(k) && off < array_base(k) + 8'd3) begin
            s.hit = 1'b1;
            s.idx = SLOT_W'(2 + 3 * k + int'(off - array_base(k)));
          end
        end
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sysctl_irq_collect.sv
module sysctl_irq_collect #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stat,
  input  logic             wr_mask,
  input  logic             wr_route,
  input  logic [7:0]       wdata,
  input  logic [N_IRQ-1:0] sub_irq,
  output logic [N_IRQ-1:0] stat,
  output logic [N_IRQ-1:0] mask,
  output logic [N_IRQ-1:0] route,
  output logic             host_irq
);

  logic [N_IRQ-1:0] stat_q, stat_d;
  logic [N_IRQ-1:0] mask_q, mask_d;
  logic [N_IRQ-1:0] route_q, route_d;
  logic [N_IRQ-1:0] line_q;
  logic [N_IRQ-1:0] chg;

  always_comb begin
    chg     = sub_irq ^ line_q;
    stat_d  = wr_stat ? wdata[N_IRQ-1:0] : stat_q;
    stat_d  = (stat_d & ~chg) | (sub_irq & chg);
    mask_d  = wr_mask  ? wdata[N_IRQ-1:0] : mask_q;
    route_d = wr_route ? wdata[N_IRQ-1:0] : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      route_q <= '0;
      line_q  <= '0;
    end else begin
      stat_q <= stat_d;
      line_q <= sub_irq;
      if (wr_mask)  mask_q  <= mask_d;
      if (wr_route) route_q <= route_d;
    end
  end

  assign stat     = stat_q;
  assign mask     = mask_q;
  assign route    = route_q;
  assign host_irq = |(stat_q & mask_q);

  assert_line_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_irq != line_q) |=>
      ((stat_q & $past(sub_irq ^ line_q)) == ($past(sub_irq) & $past(sub_irq ^ line_q))));

  assert_host_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (sub_irq == line_q)) |=> (stat_q == $past(wdata[N_IRQ-1:0])));

  assert_mask_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !host_irq);

endmodule

// File: rtl/sysctl_gpo.sv
module sysctl_gpo #(
  parameter int unsigned GP_BYTES = 3,
  parameter int unsigned N_PINS   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_lvl,
  input  logic                    wr_oe,
  input  logic [LANE_W-1:0]       lane,
  input  logic [7:0]              wdata,
  output logic [GP_BYTES*8-1:0]   lvl,
  output logic [GP_BYTES*8-1:0]   oe,
  output logic [N_PINS-1:0]       pin_out
);

  localparam int unsigned LANE_W = (GP_BYTES > 1) ? $clog2(GP_BYTES) : 1;

  logic [GP_BYTES*8-1:0] lvl_q, oe_q;
  logic [N_PINS-1:0]     eff, pin_q;
  logic                  pin_upd;

  for (genvar b = 0; b < GP_BYTES; b++) begin : g_lane
    logic lvl_we, oe_we;
    always_comb begin
      lvl_we = wr_lvl && (lane == LANE_W'(b));
      oe_we  = wr_oe  && (lane == LANE_W'(b));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[b*8 +: 8] <= '0;
        oe_q[b*8 +: 8]  <= '0;
      end else begin
        if (lvl_we) lvl_q[b*8 +: 8] <= wdata;
        if (oe_we)  oe_q[b*8 +: 8]  <= wdata;
      end
    end
  end

  always_comb begin
    eff     = lvl_q[N_PINS-1:0] & oe_q[N_PINS-1:0];
    pin_upd = (eff != pin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_q <= '0;
    else if (pin_upd) pin_q <= eff;
  end

  assign lvl     = lvl_q;
  assign oe      = oe_q;
  assign pin_out = pin_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == pin_q) |=> $stable(pin_out));

  assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eff != pin_q) |=> (pin_out == $past(lvl_q[N_PINS-1:0] & oe_q[N_PINS-1:0])));

endmodule

// File: rtl/sysctl_cfg_bank.sv
module sysctl_cfg_bank #(
  parameter int unsigned SLOTS = 38
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata
);

  localparam int unsigned SLOT_W = $clog2(SLOTS);

  logic [7:0] mem_q [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic we;
    always_comb we = wr && (slot == SLOT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (we) mem_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int unsigned i = 0; i < SLOTS; i++)
      if (slot == SLOT_W'(i)) rdata = mem_q[i];
  end

  assert_lane_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && slot != '0) |=> $stable(mem_q[0]));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned N_IRQ    = 8,
  parameter int unsigned GP_BYTES = 3,
  parameter int unsigned N_PINS   = 16,
  parameter logic [7:0]  REV_ID   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic [7:0]        acc_rdata,
  input  logic [N_IRQ-1:0]  sub_irq,
  output logic              host_irq,
  output logic [N_PINS-1:0] pin_out
);

  localparam int unsigned LANE_W = (GP_BYTES > 1) ? $clog2(GP_BYTES) : 1;

  logic               win;
  logic [7:0]         off;
  logic               wr;
  logic               in_lvl, in_oe;
  logic [LANE_W-1:0]  lane;
  slot_t              cs;
  logic [N_IRQ-1:0]   stat, mask, route;
  logic [GP_BYTES*8-1:0] lvl, oe;
  logic [7:0]         cfg_rd;

  always_comb begin
    win    = acc_en && (acc_addr[ADDR_W-1:8] == '0);
    off    = acc_addr[7:0];
    wr     = win && acc_we;
    in_lvl = (off >= OFF_LVL) && (off < OFF_LVL + 8'(GP_BYTES));
    in_oe  = (off >= OFF_OE)  && (off < OFF_OE  + 8'(GP_BYTES));
    lane   = in_lvl ? LANE_W'(off - OFF_LVL) : LANE_W'(off - OFF_OE);
    cs     = cfg_lookup(off);
  end

  sysctl_irq_collect #(.N_IRQ(N_IRQ)) irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stat  (wr && off == OFF_STAT),
    .wr_mask  (wr && off == OFF_MASK),
    .wr_route (wr && off == OFF_ROUTE),
    .wdata    (acc_wdata),
    .sub_irq  (sub_irq),
    .stat     (stat),
    .mask     (mask),
    .route    (route),
    .host_irq (host_irq)
  );

  sysctl_gpo #(.GP_BYTES(GP_BYTES), .N_PINS(N_PINS)) gpo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lvl  (wr && in_lvl),
    .wr_oe   (wr && in_oe),
    .lane    (lane),
    .wdata   (acc_wdata),
    .lvl     (lvl),
    .oe      (oe),
    .pin_out (pin_out)
  );

  sysctl_cfg_bank #(.SLOTS(CFG_SLOTS)) cfg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr && cs.hit),
    .slot  (cs.idx),
    .wdata (acc_wdata),
    .rdata (cfg_rd)
  );

  always_comb begin
    acc_rdata = 8'h00;
    if (win) begin
      if (off == OFF_REV_LO)     acc_rdata = REV_ID;
      else if (off == OFF_STAT)  acc_rdata = 8'(stat);
      else if (off == OFF_MASK)  acc_rdata = 8'(mask);
      else if (off == OFF_ROUTE) acc_rdata = 8'(route);
      else if (in_lvl)           acc_rdata = lvl[lane*8 +: 8];
      else if (in_oe)            acc_rdata = oe[lane*8 +: 8];
      else if (cs.hit)           acc_rdata = cfg_rd;
    end
  end

  assert_revision_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win && off == OFF_REV_LO) |-> (acc_rdata == REV_ID));

  assert_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!win) |-> (acc_rdata == 8'h00));

  assert_far_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_we && !win) |=> ($stable(lvl) && $stable(oe) && $stable(mask)));

endmodule

// File: tb/sysctl_regs_tb_top.sv
module sysctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_we;
  logic [15:0] acc_addr;
  logic [7:0]  acc_wdata, acc_rdata;
  logic [7:0]  sub_irq;
  logic        host_irq;
  logic [15:0] pin_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  sysctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .sub_irq(sub_irq), .host_irq(host_irq), .pin_out(pin_out)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_we = 0; acc_addr = a;
    #1 d = acc_rdata;
    acc_en = 0;
  endtask

  function automatic bit stored(input int o);
    if (o == 'h50 || o == 'h52 || o == 'h54) return 1;
    if (o == 'h60 || o == 'h61) return 1;
    if ((o >= 'h64 && o <= 'h66) || (o >= 'h68 && o <= 'h6A) ||
        (o >= 'h6C && o <= 'h6E) || (o >= 'h70 && o <= 'h72) ||
        (o >= 'h80 && o <= 'h82) || (o >= 'h84 && o <= 'h86) ||
        (o >= 'h88 && o <= 'h8A)) return 1;
    if ((o >= 'h78 && o <= 'h7A) || (o >= 'h7C && o <= 'h7E)) return 1;
    if (o >= 'h98 && o <= 'hA1) return 1;
    if (o == 'hE0 || o == 'hE4 || o == 'hE5 || o == 'hFC || o == 'hFF) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] pat(input int o);
    return 8'((o * 7 + 'h35) & 'hFF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pats [5];
    pats[0] = 8'h01; pats[1] = 8'h10; pats[2] = 8'h80; pats[3] = 8'hA5; pats[4] = 8'h00;
    rst_n = 0; acc_en = 0; acc_we = 0; acc_addr = '0; acc_wdata = '0; sub_irq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R10 reset state
    chk("R10", host_irq, 0, "host_irq after reset");
    chk("R10", pin_out, 0, "pin_out after reset");
    for (int o = 0; o < 256; o++) begin
      rd(16'(o), d);
      chk(o == 8 ? "R2" : "R10", d, (o == 8) ? 3 : 0, $sformatf("reset read %0h", o));
    end

    // R3 R6 R9 R10 R2: write every offset, read all back
    for (int o = 0; o < 256; o++) wr(16'(o), pat(o));
    for (int o = 0; o < 256; o++) begin
      rd(16'(o), d);
      if (o == 8)           chk("R2", d, 3, "revision after write");
      else if (o == 9)      chk("R2", d, 0, "revision hi after write");
      else if (stored(o))   chk("R9", d, pat(o), $sformatf("stored %0h", o));
      else                  chk("R10", d, 0, $sformatf("unmapped %0h", o));
    end

    // R8 lane independence
    wr(16'h009D, 8'h5A);
    wr(16'h0061, 8'hC3);
    rd(16'h009C, d); chk("R8", d, pat('h9C), "lane 0 kept");
    rd(16'h009D, d); chk("R8", d, 8'h5A, "lane 1 new");
    rd(16'h009E, d); chk("R8", d, pat('h9E), "lane 2 kept");
    rd(16'h009F, d); chk("R8", d, pat('h9F), "lane 3 kept");
    rd(16'h0060, d); chk("R8", d, pat('h60), "16-bit low lane kept");

    // R1 out of window
    wr(16'h0152, 8'h3C);
    rd(16'h0052, d); chk("R1", d, pat('h52), "far write ignored");
    rd(16'h0108, d); chk("R1", d, 0, "far read zero");
    rd(16'h8078, d); chk("R1", d, 0, "far read high bit");

    // R4 R5 interrupt sweep
    wr(16'h0052, 8'h00);
    for (int p = 0; p < 5; p++) begin
      @(negedge clk) sub_irq = 8'h00;
      wr(16'h0050, 8'h00);
      @(negedge clk) sub_irq = pats[p];
      @(negedge clk);
      rd(16'h0050, d); chk("R4", d, pats[p], "status follows lines");
      for (int m = 0; m < 256; m++) begin
        wr(16'h0052, 8'(m));
        chk("R5", host_irq, ((pats[p] & m) != 0) ? 1 : 0, $sformatf("irq p=%0h m=%0h", pats[p], m));
      end
    end
    @(negedge clk) sub_irq = 8'hA5;
    @(negedge clk);
    wr(16'h0050, 8'h00);
    rd(16'h0050, d); chk("R3", d, 0, "host clear vs steady line");
    chk("R5", host_irq, 0, "irq after clear");
    @(negedge clk) sub_irq = 8'hA4;
    @(negedge clk);
    rd(16'h0050, d); chk("R4", d, 0, "falling line keeps zero");
    @(negedge clk) sub_irq = 8'hA5;
    @(negedge clk);
    rd(16'h0050, d); chk("R4", d, 8'h01, "line 0 rise sets bit 0");
    chk("R5", host_irq, 1, "irq after rise");

    // R6 R7 walking one
    for (int b = 0; b < 3; b++) wr(16'(8'h7C + b), 8'hFF);
    for (int b = 0; b < 3; b++) wr(16'(8'h78 + b), 8'h00);
    @(negedge clk);
    for (int i = 0; i < 24; i++) begin
      logic [15:0] prev;
      logic [23:0] v;
      prev = pin_out;
      v = 24'(1) << i;
      wr(16'h0078, v[7:0]);
      wr(16'h0079, v[15:8]);
      wr(16'h007A, v[23:16]);
      rd(16'(8'h78 + i / 8), d); chk("R6", d, 1 << (i % 8), $sformatf("level byte pin %0d", i));
      @(negedge clk);
      chk("R7", pin_out, (i < 16) ? (1 << i) : 0, $sformatf("walk pin %0d", i));
      if (i == 0) chk("R7", prev, 0, "pin before walk");
    end
    // R7 one-clock latency
    wr(16'h0078, 8'hFF);
    chk("R7", pin_out, 0, "pin not yet updated");
    @(negedge clk);
    chk("R7", pin_out, 16'h00FF, "pin one clock later");
    // R7 enable gating
    wr(16'h0079, 8'hFF);
    for (int e = 0; e < 256; e += 17) begin
      wr(16'h007C, 8'(e));
      wr(16'h007D, 8'(255 - e));
      @(negedge clk);
      chk("R7", pin_out, {8'(255 - e), 8'(e)}, $sformatf("gate e=%0h", e));
      rd(16'h007D, d); chk("R6", d, 255 - e, "enable byte 1");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule